// File: doc/BRIEF.md
# Host Register Port with CAM Bus Arbitration

This block is the processor-facing side of a frame-address filter. A host reaches it through a 16-bit port built from several signals: chip select, an address strobe, write enable, separate data-in and data-out lanes with an output-enable, and a READY handshake. The system clock times every access. The host can reach four internal registers: a control word, a status word that clears its interrupt source when read, the opcode used for learning, and an associated-data word. It can also reach four pass-through slots. Each slot runs one command or data cycle on the external content-addressable memory (CAM) bus, for either a write or a read.

The block drives the CAM bus strobe, the write gate, the command/data select, the daisy-chain enable and the CAM data lanes. The network compare sequencer shares the CAM bus through a request/grant pair. The network side always wins a tie. A host pass-through access that meets a network request waits, with READY held low, until the network releases the bus. A network request that arrives during a host cycle already on the bus is granted only when that cycle has ended.

Top module: `hostcam_port`

## Requirements
- R1: After reset, the block holds these values. READY is high and the data output enable is low. The CAM bus is idle: strobe, write gate, command select and chain enable all high, and the CAM data output enable low. Control is 0x0000, opcode is 0x0A5C, the status-clear pulse is low and no grant is given.
- R2: The 3-bit register address is captured on the falling edge of the address strobe. A change on the address lines after that edge has no effect on the access.
- R3: An access starts at the first rising clock edge on which chip select and address strobe are both low (edge E1). For an internal register, READY goes low at E1 and returns high at E1+1. A write loads its register at E1+1.
- R4: An internal register read presents data from E1+1. Address 0 returns control, 1 returns the live status input, 2 returns opcode and 3 returns the associated-data input.
- R5: With no network request, a pass-through access (address bit 2 set) drives READY low at E1 and high at E1+4. The CAM strobe is low from E1 until E1+5, so it is sampled low for exactly five cycles.
- R6: The pass-through address sets the CAM cycle type. Bit 1 clear gives a command cycle (command select low) and bit 1 set gives a data cycle (command select high). Bit 0 set drives chain enable low; bit 0 clear leaves it high. The write gate equals the host write-enable level. For writes the host data appears on the CAM data lanes with their output enable high; for reads that enable stays low.
- R7: A pass-through read returns the CAM data-lane value sampled at the edge on which READY rises.
- R8: Network priority works in both directions. If the network request is high at E1, the block issues no CAM strobe and keeps READY low while the grant stays high. The CAM cycle then starts at the first edge on which the request is low, and READY rises four edges later. A request raised while a host CAM cycle is on the bus gets no grant until that cycle has released the strobe.
- R9: The data output enable is high only while chip select is low and read data is ready. Chip select going high turns it off at once.
- R10: Reading the status register gives exactly one single-cycle status-clear pulse. Reads of other registers give none.
- R11: One strobe gives one access. Holding chip select and address strobe low after completion starts no further cycle; a new access needs the address strobe to return high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Host chip select, active low |
| as_n | input | 1 | Host address strobe, active low; its falling edge captures addr |
| we_n | input | 1 | Host write enable, low for write |
| addr | input | 3 | Host register address |
| hd_i | input | 16 | Host write data |
| hd_o | output | 16 | Host read data |
| hd_oe | output | 1 | Enable for the host data output driver |
| ready | output | 1 | Host handshake, low while an access is in progress |
| stat_i | input | 16 | Status word from the filtering logic |
| assoc_i | input | 16 | Associated-data word from the filtering logic |
| ctrl_o | output | 16 | Control register contents |
| opcode_o | output | 16 | Learning opcode register contents |
| stat_clr | output | 1 | One-cycle pulse after a status read |
| net_req | input | 1 | Network sequencer request for the CAM bus |
| net_gnt | output | 1 | CAM bus granted to the network sequencer |
| cam_e_n | output | 1 | CAM cycle strobe, active low |
| cam_w_n | output | 1 | CAM write gate, low for write |
| cam_cm_n | output | 1 | CAM command/data select, low for command |
| cam_ec_n | output | 1 | CAM daisy-chain enable, low restricts to the matching device |
| cq_o | output | 16 | CAM data lanes driven by the block |
| cq_oe | output | 1 | Enable for the CAM data lane driver |
| cq_i | input | 16 | CAM data lanes read back |

## Verification
The hardest case to reach is a network request that collides with a host pass-through cycle. The port only shows this as READY staying low and the grant changing. The stimulus therefore sets up both orders on purpose. In one, the request is raised before the host strobe, and the bench then counts clock edges from the request's release to READY rising. In the other, the request is raised one edge after a host cycle has put its strobe on the bus, and the bench checks that the grant stays low until the strobe rises. A bench-side monitor counts the cycles in which the CAM strobe is low and records the select lines at its first low sample. From these it checks the cycle length and the encoding without looking inside the design.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RACC  = 3'd1,
    S_CWAIT = 3'd2,
    S_CRUN  = 3'd3,
    S_CEND  = 3'd4,
    S_DONE  = 3'd5
  } hcp_state_t;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_STAT  = 2'd1;
  localparam logic [1:0] REG_OPC   = 2'd2;
  localparam logic [1:0] REG_ASSOC = 2'd3;

  typedef struct packed {
    logic w_n;
    logic cm_n;
    logic ec_n;
  } cam_sel_t;

  // sub[1]: 0 command, 1 data; sub[0]: 1 restricts to matching device
  function automatic cam_sel_t cam_sel(input logic [1:0] sub, input logic wr_n);
    cam_sel_t s;
    s.w_n  = wr_n;
    s.cm_n = sub[1];
    s.ec_n = ~sub[0];
    return s;
  endfunction

endpackage

// File: rtl/hcp_addr_latch.sv
module hcp_addr_latch #(
  parameter int AW = 3
) (
  input  logic          as_n,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_q
);

  // captured on the strobe's falling edge, independent of the system clock
  always_ff @(negedge as_n or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_i;
  end

endmodule

// File: rtl/hcp_regs.sv
module hcp_regs
  import hcp_pkg::*;
#(
  parameter int          DW       = 16,
  parameter logic [DW-1:0] CTRL_RST = '0,
  parameter logic [DW-1:0] OPC_RST  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] assoc_i,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] opc_o
);

  logic ctrl_en, opc_en;

  assign ctrl_en = wr_en && (sel == REG_CTRL);
  assign opc_en  = wr_en && (sel == REG_OPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_o <= CTRL_RST;
    else if (ctrl_en) ctrl_o <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opc_o <= OPC_RST;
    else if (opc_en) opc_o <= wdata;
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: rdata = ctrl_o;
      REG_STAT: rdata = stat_i;
      REG_OPC:  rdata = opc_o;
      default:  rdata = assoc_i;
    endcase
  end

  AST_WR_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel != REG_CTRL) |=> $stable(ctrl_o)) else $error("control changed on foreign write"); // R3

endmodule

// File: rtl/hcp_seq.sv
module hcp_seq
  import hcp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 3,
  parameter int CAM_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          as_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] hd_i,
  input  logic [DW-1:0] reg_rdata,
  input  logic          net_req,
  input  logic [DW-1:0] cq_i,
  output logic          reg_wr,
  output logic          ready,
  output logic          hd_oe,
  output logic [DW-1:0] hd_o,
  output logic          stat_clr,
  output logic          net_gnt,
  output logic          cam_e_n,
  output logic          cam_w_n,
  output logic          cam_cm_n,
  output logic          cam_ec_n,
  output logic [DW-1:0] cq_o,
  output logic          cq_oe
);

  localparam int CW = $clog2(CAM_LAT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(CAM_LAT);

  hcp_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          we_q, we_d;
  logic          rdy_q, rdy_d;
  logic          rdv_q, rdv_d;
  logic [DW-1:0] rbuf_q, rbuf_d;
  logic          clr_q, clr_d;
  logic          e_q, e_d;
  cam_sel_t      sel_q, sel_d;
  logic          oe_q, oe_d;
  logic [DW-1:0] cqo_q, cqo_d;

  logic start, cam_acc, host_on_bus;
  logic load_cam;
  logic load_we;

  assign start       = !cs_n && !as_n;
  assign cam_acc     = addr_q[AW-1];
  assign host_on_bus = (st_q == S_CRUN) || (st_q == S_CEND);

  // next state
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    we_d     = we_q;
    rdy_d    = rdy_q;
    rdv_d    = rdv_q;
    rbuf_d   = rbuf_q;
    clr_d    = 1'b0;
    e_d      = e_q;
    sel_d    = sel_q;
    oe_d     = oe_q;
    cqo_d    = cqo_q;
    load_cam = 1'b0;
    load_we  = we_q;

    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          rdy_d   = 1'b0;
          we_d    = we_n;
          load_we = we_n;
          if (!cam_acc)     st_d = S_RACC;
          else if (net_req) st_d = S_CWAIT;
          else              load_cam = 1'b1;
        end
      end
      S_RACC: begin
        rdy_d = 1'b1;
        st_d  = S_DONE;
        if (we_q) begin
          rdv_d  = 1'b1;
          rbuf_d = reg_rdata;
          clr_d  = (addr_q[1:0] == REG_STAT);
        end
      end
      S_CWAIT: begin
        if (!net_req) load_cam = 1'b1;
      end
      S_CRUN: begin
        if (cnt_q == CNT_LAST) begin
          rdy_d = 1'b1;
          st_d  = S_CEND;
          if (we_q) begin
            rdv_d  = 1'b1;
            rbuf_d = cq_i;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      S_CEND: begin
        st_d  = S_DONE;
        e_d   = 1'b1;
        sel_d = '{w_n: 1'b1, cm_n: 1'b1, ec_n: 1'b1};
        oe_d  = 1'b0;
      end
      S_DONE: begin
        if (as_n) begin
          st_d  = S_IDLE;
          rdv_d = 1'b0;
        end
      end
      default: st_d = S_IDLE;
    endcase

    if (load_cam) begin
      st_d  = S_CRUN;
      cnt_d = CW'(1);
      e_d   = 1'b0;
      sel_d = cam_sel(addr_q[1:0], load_we);
      oe_d  = !load_we;
      cqo_d = hd_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      we_q   <= 1'b1;
      rdy_q  <= 1'b1;
      rdv_q  <= 1'b0;
      rbuf_q <= '0;
      clr_q  <= 1'b0;
      e_q    <= 1'b1;
      sel_q  <= '{w_n: 1'b1, cm_n: 1'b1, ec_n: 1'b1};
      oe_q   <= 1'b0;
      cqo_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      we_q   <= we_d;
      rdy_q  <= rdy_d;
      rdv_q  <= rdv_d;
      rbuf_q <= rbuf_d;
      clr_q  <= clr_d;
      e_q    <= e_d;
      sel_q  <= sel_d;
      oe_q   <= oe_d;
      cqo_q  <= cqo_d;
    end
  end

  assign reg_wr   = (st_q == S_RACC) && !we_q;
  assign ready    = rdy_q;
  assign hd_oe    = rdv_q && !cs_n;
  assign hd_o     = rbuf_q;
  assign stat_clr = clr_q;
  assign net_gnt  = net_req && !host_on_bus;
  assign cam_e_n  = e_q;
  assign cam_w_n  = sel_q.w_n;
  assign cam_cm_n = sel_q.cm_n;
  assign cam_ec_n = sel_q.ec_n;
  assign cq_o     = cqo_q;
  assign cq_oe    = oe_q;

  AST_REG_RDY_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RACC) |=> ready) else $error("register access kept READY low"); // R3
  AST_CAM_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cam_e_n) |-> !ready) else $error("CAM strobe without READY low"); // R5
  AST_WR_DRIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cq_oe |-> !cam_w_n) else $error("CAM lanes driven on a read"); // R6
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CWAIT) |-> (cam_e_n && !ready)) else $error("host touched CAM while waiting"); // R8
  AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    net_gnt |-> (cam_e_n || st_q == S_CEND) && st_q != S_CRUN) else $error("grant during host cycle"); // R8
  AST_OE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    hd_oe |-> ready) else $error("host lanes driven before READY"); // R9
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> !stat_clr) else $error("status clear longer than one cycle"); // R10

endmodule

// File: rtl/hostcam_port.sv
module hostcam_port
  import hcp_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            AW       = 3,
  parameter int            CAM_LAT  = 4,
  parameter logic [DW-1:0] CTRL_RST = 16'h0000,
  parameter logic [DW-1:0] OPC_RST  = 16'h0A5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          as_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] hd_i,
  output logic [DW-1:0] hd_o,
  output logic          hd_oe,
  output logic          ready,
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] assoc_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] opcode_o,
  output logic          stat_clr,
  input  logic          net_req,
  output logic          net_gnt,
  output logic          cam_e_n,
  output logic          cam_w_n,
  output logic          cam_cm_n,
  output logic          cam_ec_n,
  output logic [DW-1:0] cq_o,
  output logic          cq_oe,
  input  logic [DW-1:0] cq_i
);

  logic [1:0]    rst_sync;
  logic          rst_s_n;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] reg_rdata;
  logic          reg_wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  hcp_addr_latch #(.AW(AW)) u_alat (
    .as_n   (as_n),
    .rst_n  (rst_n),
    .addr_i (addr),
    .addr_q (addr_q)
  );

  hcp_regs #(.DW(DW), .CTRL_RST(CTRL_RST), .OPC_RST(OPC_RST)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (reg_wr),
    .sel     (addr_q[1:0]),
    .wdata   (hd_i),
    .stat_i  (stat_i),
    .assoc_i (assoc_i),
    .rdata   (reg_rdata),
    .ctrl_o  (ctrl_o),
    .opc_o   (opcode_o)
  );

  hcp_seq #(.DW(DW), .AW(AW), .CAM_LAT(CAM_LAT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cs_n      (cs_n),
    .as_n      (as_n),
    .we_n      (we_n),
    .addr_q    (addr_q),
    .hd_i      (hd_i),
    .reg_rdata (reg_rdata),
    .net_req   (net_req),
    .cq_i      (cq_i),
    .reg_wr    (reg_wr),
    .ready     (ready),
    .hd_oe     (hd_oe),
    .hd_o      (hd_o),
    .stat_clr  (stat_clr),
    .net_gnt   (net_gnt),
    .cam_e_n   (cam_e_n),
    .cam_w_n   (cam_w_n),
    .cam_cm_n  (cam_cm_n),
    .cam_ec_n  (cam_ec_n),
    .cq_o      (cq_o),
    .cq_oe     (cq_oe)
  );

endmodule

// File: tb/hostcam_port_tb.sv
module hostcam_port_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, as_n, we_n;
  logic [2:0]  addr;
  logic [15:0] hd_i, hd_o, stat_i, assoc_i, ctrl_o, opcode_o, cq_o, cq_i;
  logic        hd_oe, ready, stat_clr, net_req, net_gnt;
  logic        cam_e_n, cam_w_n, cam_cm_n, cam_ec_n, cq_oe;

  int vectors = 0;
  int errs    = 0;
  int elow    = 0;
  int clr_cnt = 0;
  int wd      = 0;
  logic        rdy_first;
  logic        s_w, s_cm, s_ec, s_oe;
  logic [15:0] s_cq;

  always #10 clk = ~clk;

  hostcam_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .we_n(we_n),
    .addr(addr), .hd_i(hd_i), .hd_o(hd_o), .hd_oe(hd_oe), .ready(ready),
    .stat_i(stat_i), .assoc_i(assoc_i), .ctrl_o(ctrl_o), .opcode_o(opcode_o),
    .stat_clr(stat_clr), .net_req(net_req), .net_gnt(net_gnt),
    .cam_e_n(cam_e_n), .cam_w_n(cam_w_n), .cam_cm_n(cam_cm_n),
    .cam_ec_n(cam_ec_n), .cq_o(cq_o), .cq_oe(cq_oe), .cq_i(cq_i)
  );

  // bench-side observers of the CAM strobe and the clear pulse
  always @(negedge clk) begin
    if (!cam_e_n) begin
      elow = elow + 1;
      if (elow == 1) begin
        s_w = cam_w_n; s_cm = cam_cm_n; s_ec = cam_ec_n;
        s_oe = cq_oe;  s_cq = cq_o;
      end
    end
    if (stat_clr) clr_cnt = clr_cnt + 1;
  end

  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 100000) begin
      errs = errs + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors = vectors + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic begin_acc(input logic [2:0] a, input logic wr_n,
                           input logic [15:0] d, input bit scramble);
    @(negedge clk);
    addr = a; we_n = wr_n; hd_i = d; cs_n = 1'b0;
    #1 as_n = 1'b0;
    if (scramble) #1 addr = ~a;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk);
      n = n + 1;
      if (n == 1) rdy_first = ready;
    end while (!ready && n < 40);
  endtask

  task automatic end_acc();
    @(negedge clk);
    as_n = 1'b1; cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ready == 1'b1,   "R1", "ready",   ready, 1);
    chk(hd_oe == 1'b0,   "R1", "hd_oe",   hd_oe, 0);
    chk({cam_e_n, cam_w_n, cam_cm_n, cam_ec_n} == 4'hF, "R1", "cam idle",
        {cam_e_n, cam_w_n, cam_cm_n, cam_ec_n}, 4'hF);
    chk(cq_oe == 1'b0,   "R1", "cq_oe",   cq_oe, 0);
    chk(ctrl_o == 16'h0, "R1", "ctrl",    ctrl_o, 0);
    chk(opcode_o == 16'h0A5C, "R1", "opcode", opcode_o, 16'h0A5C);
    chk(stat_clr == 1'b0 && net_gnt == 1'b0, "R1", "clr/gnt", {stat_clr, net_gnt}, 0);
  endtask

  task automatic t_reg_rw();
    int n;
    begin_acc(3'd0, 1'b0, 16'h2109, 1'b0);
    wait_rdy(n);
    chk(rdy_first == 1'b0, "R3", "write READY low at E1", rdy_first, 0);
    chk(n == 2, "R3", "write READY edges", n, 2);
    chk(ctrl_o == 16'h2109, "R3", "control loaded", ctrl_o, 16'h2109);
    end_acc();
    begin_acc(3'd0, 1'b1, 16'h0, 1'b0);
    wait_rdy(n);
    chk(n == 2, "R4", "read READY edges", n, 2);
    chk(hd_oe == 1'b1 && hd_o == 16'h2109, "R4", "control readback", hd_o, 16'h2109);
    end_acc();
  endtask

  task automatic t_addr_latch();
    int n;
    begin_acc(3'd2, 1'b0, 16'h1234, 1'b1);
    wait_rdy(n);
    end_acc();
    chk(opcode_o == 16'h1234, "R2", "opcode via latched addr", opcode_o, 16'h1234);
    chk(ctrl_o == 16'h2109, "R2", "control untouched by late addr", ctrl_o, 16'h2109);
  endtask

  task automatic t_status();
    int n;
    stat_i = 16'hA5A5; assoc_i = 16'h5AF0; clr_cnt = 0;
    begin_acc(3'd1, 1'b1, 16'h0, 1'b0);
    wait_rdy(n);
    chk(hd_o == 16'hA5A5, "R4", "status read", hd_o, 16'hA5A5);
    end_acc();
    chk(clr_cnt == 1, "R10", "clear pulses after status read", clr_cnt, 1);
    clr_cnt = 0;
    begin_acc(3'd3, 1'b1, 16'h0, 1'b0);
    wait_rdy(n);
    chk(hd_o == 16'h5AF0, "R4", "assoc read", hd_o, 16'h5AF0);
    end_acc();
    chk(clr_cnt == 0, "R10", "no clear on assoc read", clr_cnt, 0);
  endtask

  task automatic t_cs_tristate();
    int n;
    begin_acc(3'd2, 1'b1, 16'h0, 1'b0);
    wait_rdy(n);
    chk(hd_oe == 1'b1 && hd_o == 16'h1234, "R9", "driven while selected", hd_o, 16'h1234);
    @(negedge clk); cs_n = 1'b1;
    #1 chk(hd_oe == 1'b0, "R9", "off when deselected", hd_oe, 0);
    end_acc();
  endtask

  task automatic t_cam(input logic [2:0] a, input logic wr_n, input logic [15:0] d,
                       input logic ecm, input logic eec);
    int n;
    elow = 0;
    begin_acc(a, wr_n, d, 1'b0);
    wait_rdy(n);
    chk(rdy_first == 1'b0, "R5", "CAM READY low at E1", rdy_first, 0);
    chk(n == 5, "R5", "CAM READY edges", n, 5);
    if (wr_n) chk(hd_o == cq_i, "R7", "CAM read data", hd_o, cq_i);
    repeat (4) @(negedge clk);
    chk(elow == 5, "R5", "strobe low cycles", elow, 5);
    chk(ready == 1'b1 && elow == 5, "R11", "no restart while strobe held", elow, 5);
    chk({s_w, s_cm, s_ec} == {wr_n, ecm, eec}, "R6", "select encoding",
        {s_w, s_cm, s_ec}, {wr_n, ecm, eec});
    chk(s_oe == !wr_n, "R6", "CAM lane enable", s_oe, !wr_n);
    if (!wr_n) chk(s_cq == d, "R6", "CAM write data", s_cq, d);
    end_acc();
  endtask

  task automatic t_net_first();
    int n;
    elow = 0;
    @(negedge clk); net_req = 1'b1;
    begin_acc(3'd6, 1'b1, 16'h0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk(!ready && cam_e_n && net_gnt, "R8", "host held off", {ready, cam_e_n, net_gnt}, 3'b011);
    end
    @(negedge clk); net_req = 1'b0;
    wait_rdy(n);
    chk(n == 5, "R8", "edges from release to READY", n, 5);
    repeat (2) @(negedge clk);
    chk(elow == 5, "R8", "strobe cycles after wait", elow, 5);
    end_acc();
  endtask

  task automatic t_net_mid();
    int n;
    begin_acc(3'd5, 1'b0, 16'h00C3, 1'b0);
    @(posedge clk); @(negedge clk);
    net_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(net_gnt == 1'b0 && cam_e_n == 1'b0, "R8", "no grant mid host cycle",
        {net_gnt, cam_e_n}, 2'b00);
    wait_rdy(n);
    @(posedge clk); @(negedge clk);
    chk(net_gnt == 1'b1 && cam_e_n == 1'b1, "R8", "grant after strobe release",
        {net_gnt, cam_e_n}, 2'b11);
    net_req = 1'b0;
    end_acc();
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; as_n = 1'b1; we_n = 1'b1; addr = '0;
    hd_i = '0; stat_i = '0; assoc_i = '0; net_req = 1'b0; cq_i = 16'hBEEF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reg_rw();
    t_addr_latch();
    t_status();
    t_cs_tristate();
    t_cam(3'd5, 1'b0, 16'h8001, 1'b0, 1'b0);
    t_cam(3'd4, 1'b0, 16'h4242, 1'b0, 1'b1);
    t_cam(3'd6, 1'b1, 16'h0,    1'b1, 1'b1);
    cq_i = 16'h1E3C;
    t_cam(3'd7, 1'b1, 16'h0,    1'b1, 1'b0);
    t_net_first();
    t_net_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule